// File: doc/BRIEF.md
# Serial Flash Write-Protection Unit

This unit sits beside the command layer of a serial flash holding 512 KB of byte-addressable space. That space is split into eight 64 KB blocks, and each block holds sixteen 4 KB sectors. The unit keeps the protection part of the status register: a 3-bit protection code and a lock bit. It also looks at the active-low write-protect pin. For every request it answers with allow or deny. A request can be a status-register update, a byte program, a sector erase, a block erase or a chip erase.

The protection code names a region that starts at the top of the array and grows downward. A request that touches that region is denied. When the lock bit is set, status updates are frozen, but only while the write-protect pin is low. A chip erase goes ahead only when the protection code is zero. The answer is registered and appears one clock after the request strobe. It carries a separate deny flag, so the command layer can drop a refused operation without other handling.

Top module: `flash_write_guard`

## Requirements
- R1: `respValid` is high exactly in the clock after a cycle with `reqValid` high, and low after a cycle without a request.
- R2: While `respValid` is high, exactly one of `respAllow` and `respDeny` is high. While it is low, both are low.
- R3: After reset, `statusOut` reads 8'h1C: protection code 111 and lock bit 0.
- R4: Status layout: lock bit in bit 7, protection code bits 2 to 0 in status bits 4 to 2. Bits 6, 5, 1 and 0 always read 0. An accepted status update (op 0) loads these fields from `reqStatus`, and the new value is visible one clock after the request.
- R5: A status update is denied only when `wpN` is 0 and the lock bit is 1. A denied update leaves `statusOut` unchanged. While `wpN` is 1 the lock bit has no effect.
- R6: Protected blocks by code: 000 none, 001 block 7, 010 blocks 6 to 7, 011 blocks 4 to 7, and any code with its top bit set protects all blocks. The block number is address bits 18 to 16.
- R7: A byte program (op 1) is denied exactly when its address lies in a protected block.
- R8: A sector erase (op 2, sector = address bits 18 to 12) or a block erase (op 3) is denied when any byte of the addressed region is protected.
- R9: A chip erase (op 4) is allowed exactly when the protection code is 000, whatever the lock bit and pin.
- R10: Op codes 5 to 7 are denied and do not change the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-up reset |
| wpN | input | 1 | Write-protect pin, active low |
| reqValid | input | 1 | Request strobe, one cycle |
| reqKind | input | 3 | 0 status write, 1 program, 2 sector erase, 3 block erase, 4 chip erase |
| reqAddr | input | 19 | Byte address of the request |
| reqStatus | input | 8 | New status value for a status write |
| statusOut | output | 8 | Current status (protection fields) |
| respValid | output | 1 | Decision valid |
| respAllow | output | 1 | Request may proceed |
| respDeny | output | 1 | Request refused |

## Verification
A wrong stored status shows on `statusOut` one clock after the faulty update. It also shows up in the next decision that depends on it: a program or erase next to the protection boundary, or a chip erase. A wrong lock evaluation appears as a status value that changed when it should have stayed put, or stayed put when it should have changed, on the clock after the update request. Boundary addresses on both sides of each region limit expose an off-by-one in the decode within a single response.

// File: rtl/fwg_pkg.sv
package fwg_pkg;
  typedef enum logic [2:0] {
    OP_STATUS = 3'd0,
    OP_PROG   = 3'd1,
    OP_SECTOR = 3'd2,
    OP_BLOCK  = 3'd3,
    OP_CHIP   = 3'd4
  } opKind_e;

  typedef struct packed {
    logic statusWrite;
    logic decide;
  } ctrlStrobe_t;

  localparam logic [7:0] STATUS_MASK = 8'h9C;
  localparam logic [7:0] STATUS_INIT = 8'h1C;
endpackage

// File: rtl/fwg_datapath.sv
module fwg_datapath
  import fwg_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int BLOCK_W  = 3,
  parameter int SECTOR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wpN,
  input  ctrlStrobe_t       strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqStatus,
  output logic [7:0]        statusOut,
  output logic              lockActive,
  output logic              bpZero,
  output logic              hitByte,
  output logic              hitSector,
  output logic              hitBlock
);
  localparam int NUM_BLOCKS  = 1 << BLOCK_W;
  localparam int BLOCK_SHIFT = ADDR_W - BLOCK_W;
  localparam int CNT_W       = BLOCK_W + 1;
  localparam int BOUND_W     = ADDR_W + 1;

  logic [7:0]         statusReg;
  logic [2:0]         bpCode;
  logic [CNT_W-1:0]   protCount;
  logic [BOUND_W-1:0] bound;
  logic [BOUND_W-1:0] endByte, endSector, endBlock;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    statusReg <= STATUS_INIT;
    else if (strobes.statusWrite) statusReg <= reqStatus & STATUS_MASK;
  end

  assign statusOut  = statusReg;
  assign bpCode     = statusReg[4:2];
  assign lockActive = !wpN && statusReg[7];
  assign bpZero     = (bpCode == 3'd0);

  // Protected block count doubles per code step until the whole array is covered.
  always_comb begin
    if (bpCode == 3'd0)
      protCount = '0;
    else if (int'(bpCode) > BLOCK_W)
      protCount = CNT_W'(NUM_BLOCKS);
    else
      protCount = CNT_W'(1) << (bpCode - 3'd1);
  end

  assign bound = BOUND_W'(CNT_W'(NUM_BLOCKS) - protCount) << BLOCK_SHIFT;

  // Last byte of each region kind; protection starts at the top, so an
  // overlap exists exactly when the region end reaches the bound.
  assign endByte   = {1'b0, reqAddr};
  assign endSector = {1'b0, reqAddr | ADDR_W'((1 << SECTOR_W) - 1)};
  assign endBlock  = {1'b0, reqAddr | ADDR_W'((1 << BLOCK_SHIFT) - 1)};

  assign hitByte   = (protCount != '0) && (endByte   >= bound);
  assign hitSector = (protCount != '0) && (endSector >= bound);
  assign hitBlock  = (protCount != '0) && (endBlock  >= bound);

  a_r5_locked_status_frozen: assert property (@(posedge clk) disable iff (!rstN)
    lockActive |=> $stable(statusReg));
  a_r4_reserved_bits_zero: assert property (@(posedge clk) disable iff (!rstN)
    (statusReg & ~STATUS_MASK) == 8'h00);
  a_r6_all_code_hits_bottom: assert property (@(posedge clk) disable iff (!rstN)
    (bpCode[2] && reqAddr == '0) |-> hitByte);
  a_r6_zero_code_no_hit: assert property (@(posedge clk) disable iff (!rstN)
    bpZero |-> !(hitByte || hitSector || hitBlock));
endmodule

// File: rtl/fwg_ctrl.sv
module fwg_ctrl
  import fwg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [2:0]  reqKind,
  input  logic        lockActive,
  input  logic        bpZero,
  input  logic        hitByte,
  input  logic        hitSector,
  input  logic        hitBlock,
  output ctrlStrobe_t strobes,
  output logic        respValid,
  output logic        respAllow,
  output logic        respDeny
);
  logic allowNow;

  always_comb begin
    case (reqKind)
      OP_STATUS: allowNow = !lockActive;
      OP_PROG:   allowNow = !hitByte;
      OP_SECTOR: allowNow = !hitSector;
      OP_BLOCK:  allowNow = !hitBlock;
      OP_CHIP:   allowNow = bpZero;
      default:   allowNow = 1'b0;
    endcase
  end

  assign strobes.decide      = reqValid;
  assign strobes.statusWrite = reqValid && (reqKind == OP_STATUS) && allowNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respAllow <= 1'b0;
      respDeny  <= 1'b0;
    end else begin
      respValid <= strobes.decide;
      respAllow <= strobes.decide && allowNow;
      respDeny  <= strobes.decide && !allowNow;
    end
  end

  a_r1_resp_follows_req: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid);
  a_r1_no_spurious_resp: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !respValid);
  a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> $onehot({respAllow, respDeny}));
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !respValid |-> !(respAllow || respDeny));
  a_r5_lock_denies: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind == 3'd0 && lockActive) |=> respDeny);
  a_r7_program_hit_denied: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind == 3'd1 && hitByte) |=> respDeny);
  a_r9_chip_needs_zero: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind == 3'd4 && !bpZero) |=> respDeny);
  a_r10_unknown_denied: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind > 3'd4) |=> respDeny);
endmodule

// File: rtl/flash_write_guard.sv
module flash_write_guard
  import fwg_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int BLOCK_W  = 3,
  parameter int SECTOR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wpN,
  input  logic              reqValid,
  input  logic [2:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqStatus,
  output logic [7:0]        statusOut,
  output logic              respValid,
  output logic              respAllow,
  output logic              respDeny
);
  ctrlStrobe_t strobes;
  logic lockActive, bpZero, hitByte, hitSector, hitBlock;

  fwg_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .lockActive(lockActive), .bpZero(bpZero), .hitByte(hitByte),
    .hitSector(hitSector), .hitBlock(hitBlock), .strobes(strobes),
    .respValid(respValid), .respAllow(respAllow), .respDeny(respDeny)
  );

  fwg_datapath #(.ADDR_W(ADDR_W), .BLOCK_W(BLOCK_W), .SECTOR_W(SECTOR_W)) uData (
    .clk(clk), .rstN(rstN), .wpN(wpN), .strobes(strobes), .reqAddr(reqAddr),
    .reqStatus(reqStatus), .statusOut(statusOut), .lockActive(lockActive),
    .bpZero(bpZero), .hitByte(hitByte), .hitSector(hitSector), .hitBlock(hitBlock)
  );
endmodule

// File: tb/tb_flash_write_guard.sv
module tb_flash_write_guard;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wpN = 1'b1;
  logic        reqValid = 1'b0;
  logic [2:0]  reqKind = 3'd0;
  logic [18:0] reqAddr = '0;
  logic [7:0]  reqStatus = 8'h00;
  logic [7:0]  statusOut;
  logic        respValid, respAllow, respDeny;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  flash_write_guard dut (
    .clk(clk), .rstN(rstN), .wpN(wpN), .reqValid(reqValid), .reqKind(reqKind),
    .reqAddr(reqAddr), .reqStatus(reqStatus), .statusOut(statusOut),
    .respValid(respValid), .respAllow(respAllow), .respDeny(respDeny)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One request; returns the allow flag sampled one clock later.
  task automatic issue(input logic [2:0] kind, input logic [18:0] addr,
                       input logic [7:0] data, output logic allow);
    @(negedge clk);
    reqValid = 1'b1; reqKind = kind; reqAddr = addr; reqStatus = data;
    @(negedge clk);
    reqValid = 1'b0;
    check(respValid === 1'b1, "R1 valid", int'(respValid), 1);
    check((respAllow ^ respDeny) === 1'b1, "R2 one outcome",
          int'({respAllow, respDeny}), 1);
    allow = respAllow;
  endtask

  function automatic logic blockProt(input logic [2:0] code, input int blk);
    if (code == 3'd0) return 1'b0;
    if (code[2]) return 1'b1;
    return blk >= 8 - (1 << (code - 1));
  endfunction

  task automatic t_reset();
    @(negedge clk);
    check(statusOut === 8'h1C, "R3 reset status", int'(statusOut), 8'h1C);
    check(respValid === 1'b0, "R1 idle after reset", int'(respValid), 0);
    check(respAllow === 1'b0 && respDeny === 1'b0, "R2 idle flags",
          int'({respAllow, respDeny}), 0);
  endtask

  task automatic t_status_lock();
    logic a;
    wpN = 1'b1;
    issue(3'd0, '0, 8'hFF, a);
    check(a === 1'b1, "R5 pin high no lock", int'(a), 1);
    check(statusOut === 8'h9C, "R4 masked load", int'(statusOut), 8'h9C);
    wpN = 1'b0;
    issue(3'd0, '0, 8'h00, a);
    check(a === 1'b0, "R5 locked deny", int'(a), 0);
    check(statusOut === 8'h9C, "R5 locked unchanged", int'(statusOut), 8'h9C);
    wpN = 1'b1;
    issue(3'd0, '0, 8'h00, a);
    check(a === 1'b1, "R5 pin high ignores lock", int'(a), 1);
    check(statusOut === 8'h00, "R4 cleared", int'(statusOut), 8'h00);
    wpN = 1'b0;
    issue(3'd0, '0, 8'h88, a);
    check(a === 1'b1, "R5 pin low unlocked", int'(a), 1);
    check(statusOut === 8'h88, "R4 lock plus code 010", int'(statusOut), 8'h88);
    issue(3'd0, '0, 8'h00, a);
    check(a === 1'b0, "R5 relocked deny", int'(a), 0);
    check(statusOut === 8'h88, "R5 relocked unchanged", int'(statusOut), 8'h88);
    issue(3'd4, '0, 8'h00, a);
    check(a === 1'b0, "R9 chip with code 010", int'(a), 0);
    wpN = 1'b1;
    issue(3'd0, '0, 8'h80, a);
    check(statusOut === 8'h80, "R4 lock set code zero", int'(statusOut), 8'h80);
    wpN = 1'b0;
    issue(3'd4, '0, 8'h00, a);
    check(a === 1'b1, "R9 chip allowed despite lock", int'(a), 1);
    wpN = 1'b1;
  endtask

  task automatic t_code_sweep();
    logic a;
    for (int code = 0; code < 8; code++) begin
      issue(3'd0, '0, 8'(code << 2), a);
      check(statusOut === 8'(code << 2), "R4 code load", int'(statusOut), code << 2);
      for (int blk = 0; blk < 8; blk++) begin
        issue(3'd1, 19'((blk << 16) | 16'hABCD), 8'h00, a);
        check(a === !blockProt(3'(code), blk), "R6 R7 program per block",
              int'(a), int'(!blockProt(3'(code), blk)));
      end
      issue(3'd4, '0, 8'h00, a);
      check(a === (code == 0), "R9 chip per code", int'(a), int'(code == 0));
    end
  endtask

  task automatic t_erase_edges();
    logic a;
    issue(3'd0, '0, 8'h08, a);
    issue(3'd2, 19'h5F000, 8'h00, a);
    check(a === 1'b1, "R8 sector below bound", int'(a), 1);
    issue(3'd2, 19'h5FFFF, 8'h00, a);
    check(a === 1'b1, "R8 sector last below bound", int'(a), 1);
    issue(3'd2, 19'h60000, 8'h00, a);
    check(a === 1'b0, "R8 sector at bound", int'(a), 0);
    issue(3'd3, 19'h5FFFF, 8'h00, a);
    check(a === 1'b1, "R8 block 5 free", int'(a), 1);
    issue(3'd3, 19'h60123, 8'h00, a);
    check(a === 1'b0, "R8 block 6 protected", int'(a), 0);
    issue(3'd1, 19'h5FFFF, 8'h00, a);
    check(a === 1'b1, "R7 program below bound", int'(a), 1);
    issue(3'd1, 19'h60000, 8'h00, a);
    check(a === 1'b0, "R7 program at bound", int'(a), 0);
    issue(3'd0, '0, 8'h0C, a);
    issue(3'd3, 19'h3FFFF, 8'h00, a);
    check(a === 1'b1, "R8 block 3 free code 011", int'(a), 1);
    issue(3'd2, 19'h40FFF, 8'h00, a);
    check(a === 1'b0, "R8 sector in block 4", int'(a), 0);
  endtask

  task automatic t_unknown();
    logic a;
    issue(3'd0, '0, 8'h04, a);
    for (int k = 5; k < 8; k++) begin
      issue(3'(k), 19'h00000, 8'hFF, a);
      check(a === 1'b0, "R10 unknown denied", int'(a), 0);
      check(statusOut === 8'h04, "R10 status kept", int'(statusOut), 8'h04);
    end
    @(negedge clk);
    check(respValid === 1'b0, "R1 no request no response", int'(respValid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_status_lock();
    t_code_sweep();
    t_erase_edges();
    t_unknown();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule